// File: doc/BRIEF.md
# Key Storage Command Controller

This block keeps cryptographic keys in a private on-chip key area and manages them through a small 32-bit register bus. Software first describes a key in a metadata register, which holds its size, its readable and revoked flags, its number and its location. It loads up to eight entry words and then writes a command code together with a start bit. The controller runs the command one storage word per cycle. It moves key words between the entry registers and the key area, keeps a per-slot attribute table and the free byte count, and reports completion through done and error flags that can drive an interrupt.

Key creation takes the lowest-numbered empty slot and writes that slot number back into the metadata register. Key reads return the stored words through the entry registers, which are wiped once the last word of the key has been read. Bulk commands sweep the whole key area. A tamper pulse, when armed by the control register, stops whatever command is running and destroys every key.

Top module: `keystore_ctrl`

## Requirements
- R1: After reset the control and status registers read 0, the free-space register (byte offset 0x0C, bits 12:0) reads 1024, and `irq` is low.
- R2: Writing control bit 8 together with start (bit 0) sweeps the key area and drops every key. When the sweep ends, bit 8 clears itself and status bit 7 (initialized) reads 1. Any other command started before the first initialization ends with the error flag set.
- R3: Status bit 0 (done) and bit 1 (error) are cleared only by writing 1 to them. Writing 0 leaves them unchanged. Status bit 2 reads 1 while a command runs.
- R4: `irq` is high exactly while control bit 15 is 1 and status bit 0 or bit 1 is 1.
- R5: Command code 1 in control bits 3:1 is create. With size code 0 (128 bits, 4 words, 16 bytes) or size code 6 (256 bits, 8 words, 32 bytes) in metadata bits 12:8, it stores the entry words in the lowest empty slot and writes that slot number into metadata bits 25:20. It then clears all entry words and sets done.
- R6: A create whose size code is neither 0 nor 6, or that finds no empty slot or too few free bytes, sets the error flag and leaves the free byte count unchanged.
- R7: Code 0 (read) copies the key named by metadata bits 25:20 into the entry words (byte offsets 0x20 to 0x3C). A bus read of the key's last word (word 3 or word 7) clears all entry words. Reading an empty slot, or a key created with metadata bit 2 (readable) at 0, or a revoked key, sets the error flag, and the entry words then stay 0.
- R8: The free-space field shows the free bytes of the 1 KiB key area. Status bit 3 (full) is 1 when no slot is empty or fewer than 16 bytes are free.
- R9: Code 2 erases one key. It succeeds only when metadata bits 31:30 are 0 (on-chip area) and the named slot holds a key; it then returns the key's bytes and slot. Otherwise it sets the error flag.
- R10: Code 3 (erase all, needs location 0, else error) and code 5 (remanence wipe, any location) overwrite the whole key area with zeros, drop every key and restore 1024 free bytes.
- R11: Code 4 revokes the named key, and later reads of that key fail. A key created with metadata bit 3 set is revoked from the start.
- R12: With control bit 14 set, a one-cycle pulse on `tamper` aborts any running command, wipes the area and drops every key without setting done. With bit 14 clear, the pulse has no effect.
- R13: Control writes made while status bit 2 is 1 are ignored. Command codes 6 and 7 end with the error flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tamper | input | 1 | Synchronous tamper event pulse |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted slot table or free byte counter becomes visible on the very next register read, either in the free-space field or in the key number returned by the next create. The sweeps fill all 32 slots with keys of both sizes, so an off-by-one in the lowest-empty-slot search or in the byte accounting shows up as a wrong number or count within one command. A wrong word index or a clear fired too early in the transfer path corrupts the data read back through the entry words in the same read-out. A flag or interrupt that sets or clears at the wrong time shows up in the status read that follows the command.

// File: rtl/keystore_pkg.sv
package keystore_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_WALK,
        ST_FIN
    } ks_state_e;

    typedef enum logic [2:0] {
        J_READ,
        J_CREATE,
        J_ERASE1,
        J_CLEAR,
        J_REVOKE,
        J_INIT,
        J_TAMPER
    } ks_job_e;

    typedef struct packed {
        logic valid;
        logic readable;
        logic revoked;
        logic wide;
    } ks_attr_t;

    localparam logic [2:0] OPC_READ     = 3'd0;
    localparam logic [2:0] OPC_CREATE   = 3'd1;
    localparam logic [2:0] OPC_ERASE1   = 3'd2;
    localparam logic [2:0] OPC_ERASEALL = 3'd3;
    localparam logic [2:0] OPC_REVOKE   = 3'd4;
    localparam logic [2:0] OPC_WIPE     = 3'd5;

    localparam logic [4:0] SZ_128   = 5'd0;
    localparam logic [4:0] SZ_256   = 5'd6;
    localparam logic [1:0] LOC_SRAM = 2'd0;

    localparam int REG_CTL    = 0;
    localparam int REG_META   = 1;
    localparam int REG_STS    = 2;
    localparam int REG_FREE   = 3;
    localparam int REG_ENTRY0 = 8;

    function automatic logic size_known(input logic [4:0] code);
        return (code == SZ_128) || (code == SZ_256);
    endfunction

endpackage

// File: rtl/keystore_key_mem.sv
module keystore_key_mem #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/keystore_slot_table.sv
module keystore_slot_table
    import keystore_pkg::*;
#(
    parameter int SLOTS      = 32,
    parameter int AREA_BYTES = 1024,
    parameter int WIDE_BYTES = 32,
    parameter int FREE_W     = 13,
    parameter int SLOT_W     = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic              alloc_en,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  ks_attr_t          alloc_attr,
    input  logic              drop_en,
    input  logic [SLOT_W-1:0] drop_slot,
    input  logic              revoke_en,
    input  logic [SLOT_W-1:0] revoke_slot,
    input  logic [SLOT_W-1:0] look_slot,
    output ks_attr_t          look_attr,
    output logic [SLOT_W-1:0] free_slot,
    output logic              have_slot,
    output logic [FREE_W-1:0] free_bytes
);
    localparam logic [FREE_W-1:0] WIDE_B   = FREE_W'(WIDE_BYTES);
    localparam logic [FREE_W-1:0] NARROW_B = FREE_W'(WIDE_BYTES / 2);
    localparam logic [FREE_W-1:0] FULL_B   = FREE_W'(AREA_BYTES);

    ks_attr_t          tbl [SLOTS];
    logic [FREE_W-1:0] free_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            for (int i = 0; i < SLOTS; i++) tbl[i] <= '0;
            free_q <= FULL_B;
        end else begin
            if (alloc_en) begin
                tbl[alloc_slot] <= alloc_attr;
                free_q <= free_q - (alloc_attr.wide ? WIDE_B : NARROW_B);
            end
            if (drop_en) begin
                tbl[drop_slot] <= '0;
                free_q <= free_q + (tbl[drop_slot].wide ? WIDE_B : NARROW_B);
            end
            if (revoke_en) tbl[revoke_slot].revoked <= 1'b1;
        end
    end

    // lowest-numbered empty slot wins
    always_comb begin
        have_slot = 1'b0;
        free_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!tbl[i].valid) begin
                have_slot = 1'b1;
                free_slot = SLOT_W'(i);
            end
        end
    end

    assign look_attr  = tbl[look_slot];
    assign free_bytes = free_q;

    a_r8_free_bounded: assert property (@(posedge clk) disable iff (rst)
        free_q <= FULL_B);
    a_r5_alloc_into_empty: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !tbl[alloc_slot].valid);
    a_r9_drop_only_held: assert property (@(posedge clk) disable iff (rst)
        drop_en |-> tbl[drop_slot].valid);
endmodule

// File: rtl/keystore_ctrl.sv
module keystore_ctrl
    import keystore_pkg::*;
#(
    parameter int SLOTS      = 32,
    parameter int AREA_BYTES = 1024,
    parameter int KEY_WORDS  = 8,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tamper,
    output logic              irq
);
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int WIDX_W     = $clog2(KEY_WORDS);
    localparam int MEM_DEPTH  = SLOTS * KEY_WORDS;
    localparam int MEM_AW     = $clog2(MEM_DEPTH);
    localparam int FREE_W     = 13;
    localparam int WIDE_BYTES = KEY_WORDS * 4;
    localparam logic [FREE_W-1:0] WIDE_B   = FREE_W'(WIDE_BYTES);
    localparam logic [FREE_W-1:0] NARROW_B = FREE_W'(WIDE_BYTES / 2);

    // register state
    logic [2:0]  ctl_op;
    logic        ctl_init, ctl_tclr, ctl_ien;
    logic [31:0] meta_q;
    logic        done_q, err_q, init_done_q;
    logic [31:0] entry_q [KEY_WORDS];
    logic        rd_armed;
    logic [WIDX_W-1:0] rd_last;

    // engine state
    ks_state_e         state;
    ks_job_e           job;
    logic [MEM_AW-1:0] cnt;
    logic [SLOT_W-1:0] job_slot;
    logic              job_wide, job_rd, job_rv;

    // bus decode
    logic [ADDR_W-3:0] word;
    logic              aligned, in_entry, wr_ctl, wr_meta, wr_sts, wr_entry, rd_entry;
    logic [WIDX_W-1:0] eidx;
    assign word     = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign in_entry = aligned && (int'(word) >= REG_ENTRY0) && (int'(word) < REG_ENTRY0 + KEY_WORDS);
    assign eidx     = WIDX_W'(int'(word) - REG_ENTRY0);
    assign wr_ctl   = bus_sel && bus_write && aligned && (int'(word) == REG_CTL);
    assign wr_meta  = bus_sel && bus_write && aligned && (int'(word) == REG_META);
    assign wr_sts   = bus_sel && bus_write && aligned && (int'(word) == REG_STS);
    assign wr_entry = bus_sel && bus_write && in_entry;
    assign rd_entry = bus_sel && !bus_write && in_entry;

    // metadata fields
    logic [4:0] m_size;
    logic [5:0] m_num;
    logic [1:0] m_loc;
    assign m_size = meta_q[12:8];
    assign m_num  = meta_q[25:20];
    assign m_loc  = meta_q[31:30];

    // slot table
    ks_attr_t          look_attr, alloc_attr;
    logic [SLOT_W-1:0] free_slot;
    logic              have_slot, alloc_en, drop_en, revoke_en, clr_all, fin;
    logic [FREE_W-1:0] free_bytes;
    logic              busy, full, tamper_hit, tgt_ok;

    assign busy       = (state != ST_IDLE);
    assign tamper_hit = tamper && ctl_tclr;
    assign fin        = (state == ST_FIN) && !tamper_hit;
    assign alloc_en   = fin && (job == J_CREATE);
    assign drop_en    = fin && (job == J_ERASE1);
    assign revoke_en  = fin && (job == J_REVOKE);
    assign clr_all    = fin && (job == J_CLEAR || job == J_INIT || job == J_TAMPER);
    assign alloc_attr = '{valid: 1'b1, readable: job_rd, revoked: job_rv, wide: job_wide};
    assign tgt_ok     = (int'(m_num) < SLOTS) && look_attr.valid;
    assign full       = !have_slot || (free_bytes < NARROW_B);

    keystore_slot_table #(
        .SLOTS(SLOTS), .AREA_BYTES(AREA_BYTES), .WIDE_BYTES(WIDE_BYTES),
        .FREE_W(FREE_W), .SLOT_W(SLOT_W)
    ) u_table (
        .clk(clk), .rst(rst), .clr_all(clr_all),
        .alloc_en(alloc_en), .alloc_slot(job_slot), .alloc_attr(alloc_attr),
        .drop_en(drop_en), .drop_slot(job_slot),
        .revoke_en(revoke_en), .revoke_slot(job_slot),
        .look_slot(m_num[SLOT_W-1:0]), .look_attr(look_attr),
        .free_slot(free_slot), .have_slot(have_slot), .free_bytes(free_bytes)
    );

    // key area
    logic [WIDX_W-1:0] widx, last_idx;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_we;
    logic [31:0]       mem_wdata, mem_rdata;
    assign widx      = cnt[WIDX_W-1:0];
    assign last_idx  = job_wide ? WIDX_W'(KEY_WORDS - 1) : WIDX_W'(KEY_WORDS / 2 - 1);
    assign mem_addr  = (state == ST_WALK) ? cnt : {job_slot, widx};
    assign mem_we    = (state == ST_WALK) || ((state == ST_XFER) && (job != J_READ));
    assign mem_wdata = ((state == ST_XFER) && (job == J_CREATE)) ? entry_q[widx] : 32'h0;

    keystore_key_mem #(.DEPTH(MEM_DEPTH), .W(32), .AW(MEM_AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(mem_addr), .rdata(mem_rdata)
    );

    // command decode at launch
    ks_job_e           s_job;
    ks_state_e         s_state;
    logic              s_err, s_wide;
    logic [SLOT_W-1:0] s_slot;
    logic [FREE_W-1:0] need_b;
    assign need_b = (m_size == SZ_256) ? WIDE_B : NARROW_B;

    always_comb begin
        s_job   = J_READ;
        s_state = ST_XFER;
        s_err   = 1'b0;
        s_slot  = m_num[SLOT_W-1:0];
        s_wide  = look_attr.wide;
        if (bus_wdata[8]) begin
            s_job   = J_INIT;
            s_state = ST_WALK;
        end else if (!init_done_q) begin
            s_err = 1'b1;
        end else begin
            case (bus_wdata[3:1])
                OPC_READ: s_err = !(tgt_ok && look_attr.readable && !look_attr.revoked);
                OPC_CREATE: begin
                    s_job  = J_CREATE;
                    s_slot = free_slot;
                    s_wide = (m_size == SZ_256);
                    s_err  = !(size_known(m_size) && have_slot && free_bytes >= need_b);
                end
                OPC_ERASE1: begin
                    s_job = J_ERASE1;
                    s_err = !(tgt_ok && m_loc == LOC_SRAM);
                end
                OPC_ERASEALL: begin
                    s_job   = J_CLEAR;
                    s_state = ST_WALK;
                    s_err   = (m_loc != LOC_SRAM);
                end
                OPC_REVOKE: begin
                    s_job   = J_REVOKE;
                    s_state = ST_FIN;
                    s_err   = !tgt_ok;
                end
                OPC_WIPE: begin
                    s_job   = J_CLEAR;
                    s_state = ST_WALK;
                end
                default: s_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_op <= '0; ctl_init <= 1'b0; ctl_tclr <= 1'b0; ctl_ien <= 1'b0;
            meta_q <= '0; done_q <= 1'b0; err_q <= 1'b0; init_done_q <= 1'b0;
            for (int i = 0; i < KEY_WORDS; i++) entry_q[i] <= '0;
            rd_armed <= 1'b0; rd_last <= '0;
            state <= ST_IDLE; job <= J_READ; cnt <= '0;
            job_slot <= '0; job_wide <= 1'b0; job_rd <= 1'b0; job_rv <= 1'b0;
        end else begin
            if (wr_ctl && !busy) begin
                ctl_op   <= bus_wdata[3:1];
                ctl_init <= bus_wdata[8];
                ctl_tclr <= bus_wdata[14];
                ctl_ien  <= bus_wdata[15];
            end
            if (wr_meta) meta_q <= bus_wdata;
            if (wr_sts && bus_wdata[0]) done_q <= 1'b0;
            if (wr_sts && bus_wdata[1]) err_q  <= 1'b0;
            if (wr_entry) entry_q[eidx] <= bus_wdata;
            if (rd_entry && rd_armed && eidx == rd_last) begin
                for (int i = 0; i < KEY_WORDS; i++) entry_q[i] <= '0;
                rd_armed <= 1'b0;
            end

            if (tamper_hit) begin
                state    <= ST_WALK;
                job      <= J_TAMPER;
                cnt      <= '0;
                rd_armed <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: if (wr_ctl && bus_wdata[0]) begin
                        rd_armed <= 1'b0;
                        if (s_err) begin
                            err_q <= 1'b1;
                        end else begin
                            state    <= s_state;
                            job      <= s_job;
                            job_slot <= s_slot;
                            job_wide <= s_wide;
                            job_rd   <= meta_q[2];
                            job_rv   <= meta_q[3];
                            cnt      <= '0;
                        end
                    end
                    ST_XFER: begin
                        if (job == J_READ) entry_q[widx] <= mem_rdata;
                        cnt <= cnt + 1'b1;
                        if (widx == last_idx) state <= ST_FIN;
                    end
                    ST_WALK: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == MEM_AW'(MEM_DEPTH - 1)) state <= ST_FIN;
                    end
                    ST_FIN: begin
                        state <= ST_IDLE;
                        if (job != J_TAMPER) done_q <= 1'b1;
                        if (job == J_CREATE) meta_q[25:20] <= 6'(job_slot);
                        if (job == J_CREATE || job == J_TAMPER)
                            for (int i = 0; i < KEY_WORDS; i++) entry_q[i] <= '0;
                        if (job == J_READ) begin
                            rd_armed <= 1'b1;
                            rd_last  <= last_idx;
                        end
                        if (job == J_INIT) begin
                            ctl_init    <= 1'b0;
                            init_done_q <= 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_entry) bus_rdata = entry_q[eidx];
        else if (aligned) begin
            case (int'(word))
                REG_CTL:  bus_rdata = {16'b0, ctl_ien, ctl_tclr, 5'b0, ctl_init, 4'b0, ctl_op, busy};
                REG_META: bus_rdata = meta_q;
                REG_STS:  bus_rdata = {24'b0, init_done_q, 3'b0, full, busy, err_q, done_q};
                REG_FREE: bus_rdata = {{(32 - FREE_W){1'b0}}, free_bytes};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = ctl_ien && (done_q || err_q);

    a_r3_done_w1c: assert property (@(posedge clk) disable iff (rst)
        $fell(done_q) |-> $past(wr_sts && bus_wdata[0]));
    a_r3_err_w1c: assert property (@(posedge clk) disable iff (rst)
        $fell(err_q) |-> $past(wr_sts && bus_wdata[1]));
    a_r2_init_selfclear: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl_init) && !$past(wr_ctl)) |-> init_done_q);
    a_r13_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_ctl && !tamper_hit) |=> (job == $past(job)));
    a_r12_tamper_sweep: assert property (@(posedge clk) disable iff (rst)
        tamper_hit |=> (state == ST_WALK && job == J_TAMPER));
endmodule

// File: tb/test_keystore_ctrl.sv
module test_keystore_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, we = 1'b0, tamper = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0, fails = 0;
    bit          finished = 0;
    logic [31:0] ctl_base = '0;

    localparam int A_CTL = 'h00, A_META = 'h04, A_STS = 'h08, A_FREE = 'h0C, A_ENT = 'h20;

    always #2 clk = ~clk;

    keystore_ctrl i_keystore_ctrl (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_write(we), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rdata), .tamper(tamper), .irq(irq)
    );

    function automatic logic [31:0] kv(input int s, input int w, input int tag);
        return 32'(tag) * 32'h1000_0000 ^ 32'(s) * 32'h0001_0100 ^ 32'(w) * 32'h11 ^ 32'h5A3C_96E1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); sel = 1; we = 1; addr = 8'(a); wd = d;
        @(negedge clk); sel = 0; we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); sel = 1; we = 0; addr = 8'(a);
        #1 d = rdata;
        @(negedge clk); sel = 0;
    endtask

    task automatic wait_idle(output logic [31:0] st);
        int n = 0;
        do begin rd(A_STS, st); n++; end while (st[2] && n < 4000);
    endtask

    task automatic cmd(input logic [2:0] op, output logic [31:0] st);
        wr(A_CTL, ctl_base | {28'b0, op, 1'b1});
        wait_idle(st);
    endtask

    task automatic set_meta(input int num, input int size, input int rdbl, input int rvk, input int loc);
        wr(A_META, (32'(loc) << 30) | (32'(num) << 20) | (32'(size) << 8) | (32'(rvk) << 3) | (32'(rdbl) << 2));
    endtask

    task automatic load(input int nw, input int s, input int tag);
        for (int w = 0; w < nw; w++) wr(A_ENT + 4 * w, kv(s, w, tag));
    endtask

    // create a key whose expected slot is s; returns status and assigned number
    task automatic create(input int size, input int rdbl, input int rvk, input int tag,
                          input int s, output logic [31:0] st, output int num);
        logic [31:0] m;
        set_meta(0, size, rdbl, rvk, 0);
        load(size == 6 ? 8 : 4, s, tag);
        cmd(3'd1, st);
        rd(A_META, m);
        num = int'(m[25:20]);
        wr(A_STS, 3);
    endtask

    task automatic pulse_tamper;
        @(negedge clk); tamper = 1;
        @(negedge clk); tamper = 0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] d, st;
        int num, mism;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(A_CTL, d);  chk("R1 ctl reset", d, 0);
        rd(A_STS, d);  chk("R1 status reset", d, 0);
        rd(A_FREE, d); chk("R1 free reset", d, 1024);
        chk("R1 irq reset", irq, 0);

        // R2 commands before init fail
        set_meta(0, 0, 1, 0, 0);
        cmd(3'd1, st); chk("R2 create before init errs", st[1:0], 2'b10);
        // R3 writing 0 has no effect
        wr(A_STS, 0); rd(A_STS, d); chk("R3 write 0 keeps error", d[1:0], 2'b10);
        // R4 interrupt masking
        chk("R4 irq masked", irq, 0);
        wr(A_CTL, 32'h8000); chk("R4 irq raised by enable", irq, 1);
        wr(A_STS, 2); rd(A_STS, d); chk("R3 w1c clears error", d[1:0], 0);
        chk("R4 irq drops with flags", irq, 0);
        wr(A_CTL, 0);

        // R2 initialization
        wr(A_CTL, 32'h101); wait_idle(st);
        chk("R2 init done status", {st[7], st[0]}, 2'b11);
        rd(A_CTL, d); chk("R2 init bit self clears", d[8], 0);
        wr(A_STS, 3);

        // R13 undefined codes
        cmd(3'd6, st); chk("R13 code 6 errs", st[1:0], 2'b10); wr(A_STS, 3);
        cmd(3'd7, st); chk("R13 code 7 errs", st[1:0], 2'b10); wr(A_STS, 3);

        // R5 R8 sweep of 32 narrow keys (slot 5 unreadable, slot 7 revoked at creation)
        for (int i = 0; i < 32; i++) begin
            create(0, (i != 5) ? 1 : 0, (i == 7) ? 1 : 0, 1, i, st, num);
            chk("R5 create done", st[1:0], 2'b01);
            chk("R5 lowest slot number", num, i);
            rd(A_FREE, d); chk("R8 free bytes narrow", d, 32'(1024 - 16 * (i + 1)));
            rd(A_ENT, d); chk("R5 entry cleared", d, 0);
        end
        rd(A_STS, d); chk("R8 full by slots", d[3], 1);
        create(0, 1, 0, 1, 0, st, num); chk("R6 create when full errs", st[1:0], 2'b10);
        rd(A_FREE, d); chk("R6 free unchanged", d, 512);

        // R7 read-back of every slot
        for (int s = 0; s < 32; s++) begin
            set_meta(s, 0, 1, 0, 0);
            cmd(3'd0, st);
            if (s == 5 || s == 7) begin
                chk("R7 blocked read errs", st[1:0], 2'b10);
                rd(A_ENT, d); chk("R7 blocked entry zero", d, 0);
                rd(A_ENT + 12, d); chk("R11 revoked entry zero", d, 0);
            end else begin
                chk("R7 read done", st[1:0], 2'b01);
                mism = 0;
                if (s == 0) begin
                    rd(A_ENT, d); rd(A_ENT, d);
                    chk("R7 non-last read keeps data", d, kv(0, 0, 1));
                end
                for (int w = 0; w < 4; w++) begin
                    rd(A_ENT + 4 * w, d);
                    if (d !== kv(s, w, 1)) mism++;
                end
                chk("R7 read data matches", mism, 0);
                rd(A_ENT, d); chk("R7 last word read clears", d, 0);
            end
            wr(A_STS, 3);
        end

        // R11 revoke command
        set_meta(2, 0, 1, 0, 0);
        cmd(3'd4, st); chk("R11 revoke done", st[1:0], 2'b01); wr(A_STS, 3);
        cmd(3'd0, st); chk("R11 revoked read errs", st[1:0], 2'b10); wr(A_STS, 3);

        // R9 erase one
        set_meta(3, 0, 1, 0, 1);
        cmd(3'd2, st); chk("R9 non-area location errs", st[1:0], 2'b10); wr(A_STS, 3);
        rd(A_FREE, d); chk("R9 free unchanged on error", d, 512);
        set_meta(3, 0, 1, 0, 0);
        cmd(3'd2, st); chk("R9 erase done", st[1:0], 2'b01); wr(A_STS, 3);
        rd(A_FREE, d); chk("R9 bytes returned", d, 528);
        rd(A_STS, d); chk("R8 not full after erase", d[3], 0);
        cmd(3'd0, st); chk("R7 read of empty slot errs", st[1:0], 2'b10); wr(A_STS, 3);
        cmd(3'd2, st); chk("R9 erase of empty slot errs", st[1:0], 2'b10); wr(A_STS, 3);

        // R6 unsupported size
        set_meta(0, 3, 1, 0, 0);
        cmd(3'd1, st); chk("R6 bad size errs", st[1:0], 2'b10); wr(A_STS, 3);
        rd(A_FREE, d); chk("R6 free unchanged bad size", d, 528);

        // R5 wide key fills the freed slot
        create(6, 1, 0, 2, 3, st, num);
        chk("R5 wide create done", st[1:0], 2'b01);
        chk("R5 wide lands in slot 3", num, 3);
        rd(A_FREE, d); chk("R8 free after wide", d, 496);
        set_meta(3, 0, 1, 0, 0);
        cmd(3'd0, st); chk("R7 wide read done", st[1:0], 2'b01); wr(A_STS, 3);
        mism = 0;
        for (int w = 0; w < 8; w++) begin
            rd(A_ENT + 4 * w, d);
            if (d !== kv(3, w, 2)) mism++;
        end
        chk("R7 wide data matches", mism, 0);
        rd(A_ENT + 16, d); chk("R7 word 7 read clears", d, 0);

        // R10 erase all
        set_meta(0, 0, 1, 0, 1);
        cmd(3'd3, st); chk("R10 erase all wrong location errs", st[1:0], 2'b10); wr(A_STS, 3);
        set_meta(0, 0, 1, 0, 0);
        cmd(3'd3, st); chk("R10 erase all done", st[1:0], 2'b01); wr(A_STS, 3);
        rd(A_FREE, d); chk("R10 free restored", d, 1024);
        cmd(3'd0, st); chk("R10 keys gone", st[1:0], 2'b10); wr(A_STS, 3);

        // R8 sweep of 32 wide keys
        for (int i = 0; i < 32; i++) begin
            create(6, 1, 0, 3, i, st, num);
            chk("R5 wide sweep number", num, i);
            rd(A_FREE, d); chk("R8 free bytes wide", d, 32'(1024 - 32 * (i + 1)));
        end
        rd(A_STS, d); chk("R8 full by bytes", d[3], 1);
        create(0, 1, 0, 3, 0, st, num); chk("R6 no bytes errs", st[1:0], 2'b10);

        // R10 wipe accepts any location
        set_meta(31, 0, 1, 0, 2);
        cmd(3'd5, st); chk("R10 wipe done", st[1:0], 2'b01); wr(A_STS, 3);
        rd(A_FREE, d); chk("R10 wipe frees all", d, 1024);
        set_meta(31, 0, 1, 0, 0);
        cmd(3'd0, st); chk("R10 wiped key gone", st[1:0], 2'b10); wr(A_STS, 3);

        // R13 control write while busy ignored
        set_meta(0, 0, 1, 0, 0);
        wr(A_CTL, {28'b0, 3'd3, 1'b1});
        wr(A_CTL, 32'h8000 | {28'b0, 3'd1, 1'b1});
        wait_idle(st);
        rd(A_CTL, d); chk("R13 busy write ignored", d[15], 0);
        rd(A_FREE, d); chk("R13 no create while busy", d, 1024);
        wr(A_STS, 3);

        // R12 tamper without arming
        create(0, 1, 0, 4, 0, st, num);
        pulse_tamper();
        set_meta(0, 0, 1, 0, 0);
        cmd(3'd0, st); chk("R12 unarmed tamper ignored", st[1:0], 2'b01); wr(A_STS, 3);
        rd(A_ENT + 12, d);

        // R12 armed tamper aborts a create
        ctl_base = 32'h4000;
        set_meta(0, 0, 1, 0, 0);
        load(4, 1, 5);
        wr(A_CTL, ctl_base | {28'b0, 3'd1, 1'b1});
        pulse_tamper();
        wait_idle(st);
        chk("R12 tamper sets no done", st[1:0], 0);
        rd(A_FREE, d); chk("R12 tamper frees all", d, 1024);
        rd(A_ENT, d); chk("R12 entry words wiped", d, 0);
        cmd(3'd0, st); chk("R12 key destroyed", st[1:0], 2'b10);

        summary();
    end
endmodule